// File: doc/BRIEF.md
# Amplifier Control Register Target on a Two-Wire Bus

This block is a write-only target on a standard I2C bus. It owns one packed 8-bit control word for a stereo headphone amplifier. SCL and SDA are sampled by a fast system clock, and START and STOP conditions are detected in that clock domain. The block responds to one hard-wired write address. Each data byte that follows the address replaces the whole control word. No register pointer is involved.

The control word is split into a 5-bit volume code, a mute flag and two channel enables. A shutdown output is raised whenever neither channel is enabled. The SDA output is open-drain: the block only ever asserts a "pull low" enable, and a pad or the board resistor supplies the high level.

The bus interface is the only data path. The decoded fields are plain level outputs that always show the last byte accepted.

Top module: `amp_ctrl_i2c_target`

## Requirements
- R1: After reset the control word is 0x00: volume code 0, mute off, both channels disabled, shutdown high, and SDA not pulled.
- R2: When the address byte, received MSB first with bits captured on SCL rising edges, equals `DEV_ADDR` (default 0xEC, write bit included), the block pulls SDA low. The pull starts at the SCL falling edge after the eighth bit and covers the ninth clock.
- R3: When the address byte differs from `DEV_ADDR`, SDA is never pulled and the control word does not change until the next START.
- R4: Each data byte after an accepted address is acknowledged by pulling SDA low through the ninth clock. It is loaded into the control word at the falling SCL edge that ends its eighth bit.
- R5: Any number of data bytes may follow one address. Each one overwrites the control word in arrival order.
- R6: The control word decodes as follows: bits 7..3 are the volume code (00000 is minimum gain, 11111 is maximum), bit 2 is mute, bit 1 is the left enable and bit 0 is the right enable.
- R7: `shutdown_o` is high exactly when both enable bits are 0, and it changes only when a byte is loaded.
- R8: A START seen in the middle of a byte (address or data) discards the partial byte and restarts address reception.
- R9: A STOP (SDA rising while SCL is high) ends the transfer. Clock pulses seen after it without a new START are ignored.
- R10: SDA is released at the SCL falling edge that ends each acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| volume_o | output | 5 | Volume code, 0 = minimum gain |
| mute_o | output | 1 | Mute flag |
| left_en_o | output | 1 | Left channel enable |
| right_en_o | output | 1 | Right channel enable |
| shutdown_o | output | 1 | High when both channels are disabled |

## Verification
The bench builds the block with its default parameters: a 0xEC device address, two synchronizer stages and an 8-bit control word. The SCL period is 16 system clocks, so every SCL or SDA change reaches the receiver a few cycles before the next bus event. This makes the edge ordering that separates START and STOP from data bits, and the exact acknowledge windows, directly observable.

The bench sends the following traffic:
- frames with single and multiple data bytes;
- addresses that differ only in the direction bit or only in the top bit;
- repeated STARTs inside address and data bytes;
- clock pulses sent after a STOP.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_IGNORE
  } rx_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw_i[g]};
        prev  <= chain[LAST];
      end
    end

    assign level_o[g] = chain[LAST];
    assign rise_o[g]  = chain[LAST] & ~prev;
    assign fall_o[g]  = ~chain[LAST] & prev;
  end
endmodule

// File: rtl/i2c_frame_rx.sv
module i2c_frame_rx
  import amp_i2c_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter logic [7:0]  DEV_ADDR = 8'hEC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  output logic              sda_pull_o,
  output logic              load_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              start_c, stop_c;

  assign start_c = sda_fall_i & scl_lvl_i;
  assign stop_c  = sda_rise_i & scl_lvl_i;
  assign byte_o  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      sda_pull_o <= 1'b0;
      load_o     <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (start_c) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        state      <= ST_IDLE;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i && cnt != FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl_i};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall_i && cnt == FULL) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg == DEV_ADDR) begin
                  sda_pull_o <= 1'b1;
                  state      <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                sda_pull_o <= 1'b1;
                load_o     <= 1'b1;
                state      <= ST_DATA_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall_i) begin
              sda_pull_o <= 1'b0;
              state      <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: acknowledge pull begins only on an SCL falling edge
  a_r2_pull_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall_i));
  // R10: pull released only at SCL fall or a bus condition
  a_r10_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> $past(scl_fall_i | start_c | stop_c));
  // R3: a rejected transfer never drives the line
  a_r3_silent_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_pull_o);
  // R8: START restarts address reception from bit zero
  a_r8_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (state == ST_ADDR && cnt == '0));
  // R9: STOP returns to idle
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_c && !start_c) |=> (state == ST_IDLE && !sda_pull_o));
  // R4: every loaded byte is acknowledged
  a_r4_load_acked: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> sda_pull_o);
endmodule

// File: rtl/amp_ctrl_reg.sv
module amp_ctrl_reg #(
  parameter int BYTE_W = 8,
  parameter int VOL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic [VOL_W-1:0]  volume_o,
  output logic              mute_o,
  output logic              left_en_o,
  output logic              right_en_o,
  output logic              shutdown_o
);
  localparam int VOL_LSB  = BYTE_W - VOL_W;
  localparam int MUTE_BIT = 2;
  localparam int LEFT_BIT = 1;
  localparam int RGHT_BIT = 0;

  logic [BYTE_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (load_i) ctrl_q <= din_i;
  end

  assign volume_o   = ctrl_q[BYTE_W-1:VOL_LSB];
  assign mute_o     = ctrl_q[MUTE_BIT];
  assign left_en_o  = ctrl_q[LEFT_BIT];
  assign right_en_o = ctrl_q[RGHT_BIT];
  assign shutdown_o = ~(ctrl_q[LEFT_BIT] | ctrl_q[RGHT_BIT]);

  // R5: the word holds between loads
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ctrl_q));
  // R7: shutdown changes only as a result of a load
  a_r7_shutdown_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shutdown_o) |-> $past(load_i));
endmodule

// File: rtl/amp_ctrl_i2c_target.sv
module amp_ctrl_i2c_target #(
  parameter logic [7:0] DEV_ADDR    = 8'hEC,
  parameter int         SYNC_STAGES = 2,
  parameter int         BYTE_W      = 8,
  parameter int         VOL_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic [VOL_W-1:0] volume_o,
  output logic             mute_o,
  output logic             left_en_o,
  output logic             right_en_o,
  output logic             shutdown_o
);
  localparam int SCL_IX = 1;
  localparam int SDA_IX = 0;

  logic [1:0]        lvl, rise, fall;
  logic              load;
  logic [BYTE_W-1:0] rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   ({scl_i, sda_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  i2c_frame_rx #(.BYTE_W(BYTE_W), .DEV_ADDR(DEV_ADDR)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl_i  (lvl[SCL_IX]),
    .sda_lvl_i  (lvl[SDA_IX]),
    .scl_rise_i (rise[SCL_IX]),
    .scl_fall_i (fall[SCL_IX]),
    .sda_rise_i (rise[SDA_IX]),
    .sda_fall_i (fall[SDA_IX]),
    .sda_pull_o (sda_pull_o),
    .load_o     (load),
    .byte_o     (rx_byte)
  );

  amp_ctrl_reg #(.BYTE_W(BYTE_W), .VOL_W(VOL_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .din_i      (rx_byte),
    .volume_o   (volume_o),
    .mute_o     (mute_o),
    .left_en_o  (left_en_o),
    .right_en_o (right_en_o),
    .shutdown_o (shutdown_o)
  );

  // R1: out of reset the amplifier sits in shutdown with the line released
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (shutdown_o && !sda_pull_o && volume_o == '0));
endmodule

// File: tb/amp_ctrl_i2c_target_bench.sv
module amp_ctrl_i2c_target_bench;
  localparam int Q = 4;
  localparam logic [7:0] ADDR = 8'hEC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull, mute, len, ren, shdn;
  logic [4:0] vol;
  wire  sda_line = m_sda & ~sda_pull;

  int total = 0;
  int bad = 0;
  logic [7:0] model = 8'h00;
  logic [7:0] last_seen = 8'h00;
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  amp_ctrl_i2c_target u_amp_ctrl_i2c_target (
    .clk (clk), .rst_n (rst_n), .scl_i (m_scl), .sda_i (sda_line),
    .sda_pull_o (sda_pull), .volume_o (vol), .mute_o (mute),
    .left_en_o (len), .right_en_o (ren), .shutdown_o (shdn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic ack_slot(output bit acked);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); acked = sda_pull; wq(); m_scl = 1'b0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    ack_slot(acked);
  endtask

  // driver: pushes expected register values into the scoreboard queue
  task automatic write_frame(input logic [7:0] a, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2, input int n);
    bit ak;
    logic [7:0] d;
    bit match = (a == ADDR);
    bus_start();
    send_byte(a, ak);
    chk(ak == match, match ? "R2" : "R3", "address acknowledge", ak, match);
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      if (match && d != model) expq.push_back(d);
      if (match) model = d;
      send_byte(d, ak);
      chk(ak == match, match ? "R4" : "R3", "data acknowledge", ak, match);
      chk(sda_pull == 1'b0, "R10", "line released after ack", sda_pull, 0);
    end
    bus_stop();
    wq();
  endtask

  // monitor: every change of the decoded word must match the queue head
  always @(negedge clk) begin
    logic [7:0] cur;
    logic [7:0] e;
    if (rst_n) begin
      cur = {vol, mute, len, ren};
      if (cur != last_seen) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R5", "unexpected register change", cur, last_seen);
        end else begin
          e = expq.pop_front();
          chk(cur == e, "R5", "register sequence", cur, e);
        end
        last_seen = cur;
      end
    end
  end

  task automatic check_word(input logic [7:0] e, input string req);
    chk({vol, mute, len, ren} == e, req, "control word", {vol, mute, len, ren}, e);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit ak;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_word(8'h00, "R1");
    chk(shdn == 1'b1, "R1", "shutdown after reset", shdn, 1);
    chk(sda_pull == 1'b0, "R1", "line released after reset", sda_pull, 0);

    // R6 field layout: 0xFB = vol 31, mute 0, left 1, right 1
    write_frame(ADDR, 8'hFB, 8'h00, 8'h00, 1);
    chk(vol == 5'd31, "R6", "volume field", vol, 31);
    chk(mute == 1'b0, "R6", "mute field", mute, 0);
    chk(len == 1'b1 && ren == 1'b1, "R6", "enable fields", {len, ren}, 3);
    chk(shdn == 1'b0, "R7", "shutdown with both enabled", shdn, 0);

    // R5 several bytes in one frame, last one stays
    write_frame(ADDR, 8'h13, 8'h55, 8'hA6, 3);
    check_word(8'hA6, "R5");

    // R7 mute only, both enables low -> shutdown
    write_frame(ADDR, 8'h04, 8'h00, 8'h00, 1);
    chk(shdn == 1'b1 && mute == 1'b1 && vol == 5'd0, "R7", "shutdown with mute only",
        {shdn, mute}, 3);
    write_frame(ADDR, 8'h02, 8'h00, 8'h00, 1);
    chk(shdn == 1'b0, "R7", "left enable wakes", shdn, 0);
    write_frame(ADDR, 8'h01, 8'h00, 8'h00, 1);
    chk(shdn == 1'b0 && vol == 5'd0, "R6", "right enable only", {shdn, ren}, 1);

    // R3 mismatched addresses: direction bit set, top bit cleared
    write_frame(8'hED, 8'hFF, 8'h00, 8'h00, 1);
    check_word(8'h01, "R3");
    write_frame(8'h6C, 8'h7E, 8'h00, 8'h00, 2);
    check_word(8'h01, "R3");

    // R8 START inside the address byte
    bus_start();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    write_frame(ADDR, 8'h8A, 8'h00, 8'h00, 1);
    check_word(8'h8A, "R8");

    // R8 START inside a data byte: partial byte discarded
    bus_start();
    send_byte(ADDR, ak);
    chk(ak == 1'b1, "R2", "address acknowledge before abort", ak, 1);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    write_frame(ADDR, 8'h3D, 8'h00, 8'h00, 1);
    check_word(8'h3D, "R8");

    // R9 clock pulses after STOP without a new START are ignored
    m_scl = 1'b0; wq();
    send_byte(ADDR, ak);
    chk(ak == 1'b0, "R9", "no acknowledge without START", ak, 0);
    send_byte(8'hF8, ak);
    chk(ak == 1'b0, "R9", "no data acknowledge without START", ak, 0);
    bus_stop();
    wq();
    check_word(8'h3D, "R9");

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R5", "pending expected writes", expq.size(), 0);
    summary();
    $finish;
  end
endmodule